// File: doc/BRIEF.md
# Armable Byte Parity Checker

This block sits beside a byte-wide memory array that keeps a ninth bit with every byte. On the write side it produces the parity bit that the array stores next to the data byte. On the read side it takes the byte and its stored bit, checks them one clock later, and latches an error if the nine bits do not have odd parity. Parity is odd: the stored bit makes the number of ones across all nine bits odd.

Error reporting is controlled through one bit of a shared, write-only I/O control port. A write to the port address with that bit set arms checking and clears any latched error. A write with that bit clear disarms checking. The latched error drives exactly one of ten interrupt lines: eight vectored lines, one non-vectored line and one non-maskable line. The line is picked by a parameter, and one further parameter value leaves every line quiet.

Top module: `par_guard`

## Requirements
- R1: `parOut` equals the inverted XOR of `wrData`, so `{parOut, wrData}` always holds an odd number of ones.
- R2: A read whose nine bits (`rdData`, `rdPar`) hold an odd count of ones never sets `errFlag`.
- R3: While armed, a read with an even count of ones sets `errFlag`. The read strobe is sampled at clock edge N, the check runs at edge N+1, and `errFlag` reads 1 after edge N+1.
- R4: While disarmed, a read with an even count of ones leaves `errFlag` unchanged.
- R5: A write to the port (`ioWr`=1 and `ioAddr`==`PORT_ADDR`, default 8'hC0) with `ioData[CTRL_BIT]`=1 (default bit 6) arms checking and clears `errFlag`. The same write with that bit at 0 disarms checking and leaves `errFlag` as it was.
- R6: A write with `ioAddr` other than `PORT_ADDR` has no effect on arming or on `errFlag`. With `ioWr`=0, `ioAddr` and `ioData` have no effect.
- R7: Once set, `errFlag` stays set until an arming write or a reset. A disarming write does not clear it.
- R8: If a mismatch check and an arming write fall on the same clock edge, the clear wins and `errFlag` is 0 after that edge.
- R9: `irqLines` is 10 bits wide. Bits 0 to 7 are the vectored lines, bit 8 is the non-vectored line and bit 9 is the non-maskable line. The bit whose index equals `IRQ_SEL` follows `errFlag` and all other bits are 0. With `IRQ_SEL`=10, all bits are 0.
- R10: After reset, checking is disarmed, `errFlag` is 0 and every `irqLines` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memRd | input | 1 | Memory read strobe; read data and stored parity are valid with it |
| rdData | input | DATA_W | Byte read from the array |
| rdPar | input | 1 | Parity bit read from the array |
| wrData | input | DATA_W | Byte being written to the array |
| parOut | output | 1 | Parity bit to store with `wrData` |
| ioWr | input | 1 | I/O port write strobe |
| ioAddr | input | ADDR_W | I/O port address |
| ioData | input | IO_W | I/O port write data |
| errFlag | output | 1 | Latched parity error |
| irqLines | output | 10 | Interrupt lines; only the selected one is driven |

## Verification
The bench builds two copies that share one stimulus stream. Both keep the default port address and control bit 6. The first routes the error to vectored line 3, so the selected line and the nine silent lines can be observed together. The second uses `IRQ_SEL`=10, so a latched error with no interrupt at all is within reach. Directed sequences cover the arm, disarm and clear orderings and the clash between a clear and a check on the same edge. After them, seeded random reads and port writes run against a cycle model.

// File: rtl/par_guard_pkg.sv
package par_guard_pkg;
  localparam int unsigned IRQ_LINES = 10;

  // datapath -> control strobes
  typedef struct packed {
    logic valid;   // a check was performed this cycle
    logic bad;     // the checked nine bits had even parity
  } chkStrobes_t;
endpackage

// File: rtl/par_guard_dp.sv
module par_guard_dp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        memRd,
  input  logic [DATA_W-1:0]           rdData,
  input  logic                        rdPar,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        parOut,
  output par_guard_pkg::chkStrobes_t  chk
);
  localparam int unsigned WORD_W = DATA_W + 1;

  logic              chkPend;
  logic [WORD_W-1:0] chkWord;

  // odd parity for the stored word
  assign parOut = ~(^wrData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkPend <= 1'b0;
      chkWord <= '0;
    end else begin
      chkPend <= memRd;
      if (memRd) chkWord <= {rdPar, rdData};
    end
  end

  always_comb begin
    chk.valid = chkPend;
    chk.bad   = chkPend && !(^chkWord);
  end

  // R1: written word carries odd parity
  p_odd_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({parOut, wrData}) % 2) == 1);

  // R3: a check only follows a read strobe
  p_check_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    chk.valid |-> $past(memRd));
endmodule

// File: rtl/par_guard_ctrl.sv
module par_guard_ctrl #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IO_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hC0,
  parameter int unsigned CTRL_BIT  = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ioWr,
  input  logic [ADDR_W-1:0]           ioAddr,
  input  logic [IO_W-1:0]             ioData,
  input  par_guard_pkg::chkStrobes_t  chk,
  output logic                        errFlag
);
  logic armed;
  logic portHit;
  logic armWrite;
  logic disarmWrite;

  assign portHit     = ioWr && (ioAddr == PORT_ADDR);
  assign armWrite    = portHit && ioData[CTRL_BIT];
  assign disarmWrite = portHit && !ioData[CTRL_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (armWrite)         armed <= 1'b1;
      else if (disarmWrite) armed <= 1'b0;

      if (armWrite)                errFlag <= 1'b0;   // clear wins
      else if (chk.bad && armed)   errFlag <= 1'b1;
    end
  end

  // R5 / R8: arming write clears the flag
  p_arm_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    armWrite |=> !errFlag);

  // R7: flag is sticky unless an arming write arrives
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !armWrite) |=> errFlag);

  // R4: disarmed checking never raises the flag
  p_disarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !errFlag) |=> !errFlag);

  // R2: only a bad check raises the flag
  p_rise_needs_bad_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !chk.bad) |=> !errFlag);
endmodule

// File: rtl/par_guard.sv
module par_guard #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IO_W      = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hC0,
  parameter int unsigned CTRL_BIT  = 6,
  parameter int unsigned IRQ_SEL   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memRd,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdPar,
  input  logic [DATA_W-1:0] wrData,
  output logic              parOut,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [IO_W-1:0]   ioData,
  output logic              errFlag,
  output logic [par_guard_pkg::IRQ_LINES-1:0] irqLines
);
  localparam int unsigned NLINES = par_guard_pkg::IRQ_LINES;
  localparam logic ROUTED = (IRQ_SEL < NLINES);

  par_guard_pkg::chkStrobes_t chk;

  par_guard_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .memRd(memRd), .rdData(rdData), .rdPar(rdPar),
    .wrData(wrData), .parOut(parOut), .chk(chk)
  );

  par_guard_ctrl #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .PORT_ADDR(PORT_ADDR), .CTRL_BIT(CTRL_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
    .chk(chk), .errFlag(errFlag)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_irq
    if (i == IRQ_SEL) begin : g_sel
      assign irqLines[i] = errFlag;
    end else begin : g_idle
      assign irqLines[i] = 1'b0;
    end
  end

  // R9: at most one line, and only when an error is latched
  p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqLines != '0) == (errFlag && ROUTED));
endmodule

// File: tb/par_guard_tb.sv
module par_guard_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned SEL_A = 3;
  localparam int unsigned SEL_B = 10;
  localparam logic [7:0] PADDR = 8'hC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memRd = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic rdPar = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic ioWr = 1'b0;
  logic [7:0] ioAddr = '0;
  logic [7:0] ioData = '0;
  logic parA, parB, errA, errB;
  logic [9:0] irqA, irqB;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // model state
  bit mArmed = 0, mErr = 0, mPendBad = 0;

  always #5 clk = ~clk;

  par_guard #(.IRQ_SEL(SEL_A)) dut_i (
    .clk(clk), .rstN(rstN), .memRd(memRd), .rdData(rdData), .rdPar(rdPar),
    .wrData(wrData), .parOut(parA), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioData(ioData), .errFlag(errA), .irqLines(irqA)
  );

  par_guard #(.IRQ_SEL(SEL_B)) dutOff_i (
    .clk(clk), .rstN(rstN), .memRd(memRd), .rdData(rdData), .rdPar(rdPar),
    .wrData(wrData), .parOut(parB), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioData(ioData), .errFlag(errB), .irqLines(irqB)
  );

  function automatic bit oddPar(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic [9:0] expIrq(input int unsigned sel, input bit e);
    logic [9:0] v = '0;
    if (sel < 10) v[sel] = e;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one edge, updating the model from the inputs driven before it
  task automatic tick();
    bit portHit = ioWr && (ioAddr == PADDR);
    bit nErr = mErr;
    if (mPendBad && mArmed) nErr = 1;
    if (portHit && ioData[6]) nErr = 0;
    if (portHit) mArmed = ioData[6];
    mPendBad = memRd && !(^{rdPar, rdData});
    mErr = nErr;
    @(posedge clk);
    #1;
  endtask

  task automatic checkOuts(input string req);
    check(errA == mErr, req, errA, mErr);
    check(errB == mErr, req, errB, mErr);
    check(irqA == expIrq(SEL_A, mErr), {req, "/R9"}, irqA, expIrq(SEL_A, mErr));
    check(irqB == '0, {req, "/R9"}, irqB, 0);
    check(parA == oddPar(wrData), "R1", parA, oddPar(wrData));
  endtask

  task automatic portWr(input logic [7:0] a, input logic [7:0] d);
    ioWr = 1; ioAddr = a; ioData = d;
    tick();
    ioWr = 0;
  endtask

  task automatic rd(input logic [DW-1:0] d, input bit goodPar);
    memRd = 1; rdData = d; rdPar = goodPar ? oddPar(d) : ~oddPar(d);
    tick();
    memRd = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    tick(); tick();
    rstN = 1;
    mArmed = 0; mErr = 0; mPendBad = 0;
    tick();
    checkOuts("R10");

    // R1: parity generation over several patterns
    foreach (wrData[i]) begin
      wrData = 8'(1 << i) | 8'h10;
      #1 check(parA == oddPar(wrData), "R1", parA, oddPar(wrData));
    end
    wrData = 8'h00; #1 check(parA == 1'b1, "R1", parA, 1);
    wrData = 8'hFF; #1 check(parA == 1'b1, "R1", parA, 1);
    wrData = 8'h01; #1 check(parA == 1'b0, "R1", parA, 0);

    // R4: disarmed bad read
    rd(8'h5A, 0); tick(); checkOuts("R4");

    // R5 arm; R2 good read
    portWr(PADDR, 8'h40); checkOuts("R5");
    rd(8'h37, 1); tick(); checkOuts("R2");

    // R3: bad read armed, exact timing
    rd(8'hA5, 0);
    check(errA == 1'b0, "R3", errA, 0);   // after edge N: not yet
    tick();
    check(errA == 1'b1, "R3", errA, 1);   // after edge N+1
    checkOuts("R3");

    // R6: other address / strobe low
    portWr(8'hC1, 8'h40); checkOuts("R6");
    ioAddr = PADDR; ioData = 8'h40; tick(); checkOuts("R6");
    // R7: disarm keeps flag
    portWr(PADDR, 8'h00); checkOuts("R7");
    tick(); tick(); checkOuts("R7");
    // R5: arm clears
    portWr(PADDR, 8'h41); checkOuts("R5");
    check(errA == 1'b0, "R5", errA, 0);

    // R8: check and clear on the same edge
    rd(8'h0F, 0);
    portWr(PADDR, 8'h40);
    check(errA == 1'b0, "R8", errA, 0);
    checkOuts("R8");

    // R6: wrong address after disarm must not re-arm
    portWr(PADDR, 8'h00);
    portWr(8'h40, 8'hFF);
    rd(8'h11, 0); tick(); checkOuts("R6");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(99));
      memRd  = (r < 35);
      rdData = 8'($urandom);
      rdPar  = ($urandom_range(3) == 0) ? ~oddPar(rdData) : oddPar(rdData);
      wrData = 8'($urandom);
      ioWr   = ($urandom_range(19) == 0);
      ioAddr = ($urandom_range(2) == 0) ? 8'($urandom) : PADDR;
      ioData = 8'($urandom);
      tick();
      checkOuts("R3/R7 random");
    end
    memRd = 0; ioWr = 0;

    // R10: reset clears
    portWr(PADDR, 8'h40); rd(8'h00, 0); tick();
    check(errA == 1'b1, "R3", errA, 1);
    rstN = 0; tick(); rstN = 1;
    mArmed = 0; mErr = 0; mPendBad = 0;
    check(errA == 1'b0 && irqA == '0, "R10", errA, 0);
    rd(8'h00, 0); tick(); checkOuts("R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule